// File: doc/BRIEF.md
# Page Translation Buffer with Write Protection

This block turns a 32-bit virtual address into a 30-bit physical address using a small fully associative table of recently used page translations. The upper 20 address bits name the virtual page and the low 12 bits are the offset inside a 4 KB page. The table compares every entry at once, and the lookup is purely combinational. When one valid entry matches, the block places its 18-bit physical page number above the untouched offset. When none matches, it raises a miss exception. When a write lands on a page whose entry forbids writes, it raises a protection exception instead.

A miss handler installs translations through a refill port, one per clock. It supplies the virtual page, the physical page, a write-allow bit and the page's present bit. New pages go to the slot chosen by a round-robin pointer. A refill for a page already in the table rewrites that entry in place. A refill for a page that is not present never creates a valid entry. Reset and a flush input both empty the table.

Top module: `tlbXlate`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports missExc=1, hit=0 and pAddr=0.
- R2: When a valid entry holds virtual page vAddr[31:12] and the access is allowed, hit=1, missExc=0, protExc=0 and pAddr={entry physical page, vAddr[11:0]} in the same cycle.
- R3: When no valid entry holds vAddr[31:12], missExc=1, hit=0, protExc=0 and pAddr=0.
- R4: A write (isWrite=1) that matches an entry whose write-allow bit is 0 gives protExc=1, hit=1, missExc=0 and pAddr=0. A read of that page translates normally, and a write to a page with write-allow 1 raises no exception.
- R5: A refill presented with fillEn=1 changes lookups only after the next rising clock edge. In the cycle it is presented, the old contents still answer.
- R6: Refills of pages not already in the table fill slots 0,1,2,... in turn and wrap after slot 15. The seventeenth distinct page therefore replaces the oldest one.
- R7: A refill whose virtual page is already valid in the table rewrites that entry's physical page and write-allow bit. It does not create a duplicate and does not advance the round-robin pointer.
- R8: flush=1 invalidates every entry at the next edge and returns the pointer to slot 0. It takes precedence over a refill in the same cycle.
- R9: A refill with fillPresent=0 never makes an entry valid and leaves the pointer unchanged. If its page is in the table, that entry becomes invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| vAddr | input | 32 | Virtual address to translate |
| isWrite | input | 1 | Access is a write |
| fillEn | input | 1 | Refill request this cycle |
| fillVpn | input | 20 | Virtual page of the refill |
| fillPpn | input | 18 | Physical page of the refill |
| fillWrAllow | input | 1 | Write-allow bit of the refill |
| fillPresent | input | 1 | Page is resident; 0 forbids a valid install |
| pAddr | output | 30 | Physical address, zero on any exception |
| hit | output | 1 | A valid entry matched |
| missExc | output | 1 | Miss exception |
| protExc | output | 1 | Write-protection exception |

## Verification
The bench builds the block with its default parameters: 16 entries, 20-bit virtual pages, 18-bit physical pages and 12-bit offsets. Sixteen entries are few enough that a random pool of 24 virtual pages forces constant eviction. Directed refill runs then walk the pointer through a full wrap in a few dozen cycles. Those runs place overwrite, non-present refill and flush-versus-refill collisions at known pointer positions, so the victim slot of each later refill can be predicted.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // strobes from the refill control to the entry store
  typedef struct packed {
    logic wrEn;      // write one entry this edge
    logic wrValid;   // valid bit written with it
    logic clearAll;  // invalidate the whole table
  } tlbStrobe_t;
endpackage

// File: rtl/tlbEntryStore.sv
module tlbEntryStore
  import tlb_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 18,
  parameter int OFFSET_W = 12,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int VA_W    = VPN_W + OFFSET_W,
  localparam int PA_W    = PPN_W + OFFSET_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             fillWrAllow,
  input  logic [VA_W-1:0]  vAddr,
  input  logic             isWrite,
  output logic             fillHit,
  output logic [IDX_W-1:0] fillHitIdx,
  output logic             hit,
  output logic             missExc,
  output logic             protExc,
  output logic [PA_W-1:0]  pAddr
);

  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   vpnQ [ENTRIES];
  logic [PPN_W-1:0]   ppnQ [ENTRIES];
  logic [ENTRIES-1:0] wrAllowQ;

  logic [VPN_W-1:0]    lookVpn;
  logic [OFFSET_W-1:0] lookOffset;
  logic [ENTRIES-1:0]  lookMatch;
  logic [ENTRIES-1:0]  fillMatch;
  logic [IDX_W-1:0]    hitIdx;

  assign lookVpn    = vAddr[VA_W-1:OFFSET_W];
  assign lookOffset = vAddr[OFFSET_W-1:0];

  // parallel compare, one comparator pair per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign lookMatch[g] = validQ[g] && (vpnQ[g] == lookVpn);
    assign fillMatch[g] = validQ[g] && (vpnQ[g] == fillVpn);
  end

  // match vectors are at most one-hot, so OR-encoding yields the index
  always_comb begin
    hitIdx     = '0;
    fillHitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookMatch[i]) hitIdx     = hitIdx | IDX_W'(i);
      if (fillMatch[i]) fillHitIdx = fillHitIdx | IDX_W'(i);
    end
  end

  assign fillHit = |fillMatch;
  assign hit     = |lookMatch;
  assign missExc = !hit;
  assign protExc = hit && isWrite && !wrAllowQ[hitIdx];
  assign pAddr   = (hit && !protExc) ? {ppnQ[hitIdx], lookOffset} : '0;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) begin
      validQ <= '0;
    end else if (strobe.wrEn) begin
      validQ[wrIdx] <= strobe.wrValid;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn && !strobe.clearAll) begin
      vpnQ[wrIdx]     <= fillVpn;
      ppnQ[wrIdx]     <= fillPpn;
      wrAllowQ[wrIdx] <= fillWrAllow;
    end
  end

  // R7: the table never holds the same page twice
  assert_unique_page_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookMatch));

  // R3: a miss never drives an address
  assert_miss_no_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    missExc |-> (pAddr == '0 && !protExc));

  // R4: protection fault only on a write that matched, with no address
  assert_prot_write_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
    protExc |-> (isWrite && hit && pAddr == '0));

  // R8: a flush empties the table by the next edge
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (validQ == '0));

endmodule

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             fillEn,
  input  logic             fillPresent,
  input  logic             fillHit,
  input  logic [IDX_W-1:0] fillHitIdx,
  output tlbStrobe_t       strobe,
  output logic [IDX_W-1:0] wrIdx
);

  logic [IDX_W-1:0] ptrQ;
  logic             allocNow;

  // a new slot is taken only for a resident page not already present
  assign allocNow = !flush && fillEn && fillPresent && !fillHit;

  always_comb begin
    strobe.clearAll = flush;
    strobe.wrEn     = !flush && fillEn && (fillPresent || fillHit);
    strobe.wrValid  = fillPresent;
    wrIdx           = fillHit ? fillHitIdx : ptrQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      ptrQ <= '0;
    end else if (allocNow) begin
      ptrQ <= (ptrQ == LAST_IDX) ? '0 : ptrQ + 1'b1;
    end
  end

  // R6: each allocation moves the pointer one slot, wrapping at the end
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    allocNow |=> (ptrQ == (($past(ptrQ) == LAST_IDX) ? '0 : $past(ptrQ) + 1'b1)));

  // R7: refilling a resident page leaves the pointer alone
  assert_overwrite_keeps_ptr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && fillHit && !flush) |=> $stable(ptrQ));

  // R8: flush returns the pointer to slot 0
  assert_flush_ptr_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (ptrQ == '0));

  // R9: a non-resident refill never validates an entry
  assert_absent_no_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !fillPresent) |-> !(strobe.wrEn && strobe.wrValid));

endmodule

// File: rtl/tlbXlate.sv
module tlbXlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 18,
  parameter int OFFSET_W = 12,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int VA_W    = VPN_W + OFFSET_W,
  localparam int PA_W    = PPN_W + OFFSET_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [VA_W-1:0]  vAddr,
  input  logic             isWrite,
  input  logic             fillEn,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             fillWrAllow,
  input  logic             fillPresent,
  output logic [PA_W-1:0]  pAddr,
  output logic             hit,
  output logic             missExc,
  output logic             protExc
);

  tlbStrobe_t       strobe;
  logic [IDX_W-1:0] wrIdx;
  logic             fillHit;
  logic [IDX_W-1:0] fillHitIdx;

  tlbCtrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .flush       (flush),
    .fillEn      (fillEn),
    .fillPresent (fillPresent),
    .fillHit     (fillHit),
    .fillHitIdx  (fillHitIdx),
    .strobe      (strobe),
    .wrIdx       (wrIdx)
  );

  tlbEntryStore #(
    .ENTRIES  (ENTRIES),
    .VPN_W    (VPN_W),
    .PPN_W    (PPN_W),
    .OFFSET_W (OFFSET_W)
  ) u_store (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrIdx       (wrIdx),
    .fillVpn     (fillVpn),
    .fillPpn     (fillPpn),
    .fillWrAllow (fillWrAllow),
    .vAddr       (vAddr),
    .isWrite     (isWrite),
    .fillHit     (fillHit),
    .fillHitIdx  (fillHitIdx),
    .hit         (hit),
    .missExc     (missExc),
    .protExc     (protExc),
    .pAddr       (pAddr)
  );

endmodule

// File: tb/tlbXlate_bench.sv
module tlbXlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] vAddr = '0;
  logic        isWrite = 1'b0;
  logic        fillEn = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [17:0] fillPpn = '0;
  logic        fillWrAllow = 1'b0;
  logic        fillPresent = 1'b0;
  logic [29:0] pAddr;
  logic        hit, missExc, protExc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference table
  bit          mValid [N];
  logic [19:0] mVpn   [N];
  logic [17:0] mPpn   [N];
  bit          mWr    [N];
  int          mPtr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbXlate u_tlbXlate (
    .clk(clk), .rstN(rstN), .flush(flush), .vAddr(vAddr), .isWrite(isWrite),
    .fillEn(fillEn), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillWrAllow(fillWrAllow), .fillPresent(fillPresent),
    .pAddr(pAddr), .hit(hit), .missExc(missExc), .protExc(protExc)
  );

  function automatic void modelClear();
    for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    mPtr = 0;
  endfunction

  function automatic int modelFind(logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (mValid[i] && mVpn[i] == vpn) return i;
    return -1;
  endfunction

  // refill rules of R6, R7, R8, R9
  function automatic void modelEdge(bit fl, bit en, logic [19:0] vpn,
                                    logic [17:0] ppn, bit wr, bit pres);
    int m;
    if (fl) begin
      modelClear();
    end else if (en) begin
      m = modelFind(vpn);
      if (m >= 0) begin
        if (pres) begin mPpn[m] = ppn; mWr[m] = wr; end
        else mValid[m] = 1'b0;
      end else if (pres) begin
        mValid[mPtr] = 1'b1; mVpn[mPtr] = vpn; mPpn[mPtr] = ppn; mWr[mPtr] = wr;
        mPtr = (mPtr + 1) % N;
      end
    end
  endfunction

  task automatic checkNow(string req);
    int m;
    bit eHit, eMiss, eProt;
    logic [29:0] ePa;
    m = modelFind(vAddr[31:12]);
    eHit  = (m >= 0);
    eMiss = !eHit;
    eProt = eHit && isWrite && !mWr[m];
    ePa   = (eHit && !eProt) ? {mPpn[m], vAddr[11:0]} : 30'h0;
    checks++;
    if (hit !== eHit || missExc !== eMiss || protExc !== eProt || pAddr !== ePa) begin
      errors++;
      $display("FAIL %s va=%h wr=%0b: got hit=%0b miss=%0b prot=%0b pa=%h expected hit=%0b miss=%0b prot=%0b pa=%h",
               req, vAddr, isWrite, hit, missExc, protExc, pAddr, eHit, eMiss, eProt, ePa);
    end
  endtask

  task automatic look(logic [31:0] va, bit wr, string req);
    @(negedge clk);
    vAddr = va; isWrite = wr;
    #1;
    checkNow(req);
  endtask

  task automatic fill(logic [19:0] vpn, logic [17:0] ppn, bit wr, bit pres, bit fl);
    @(negedge clk);
    fillEn = 1'b1; fillVpn = vpn; fillPpn = ppn; fillWrAllow = wr;
    fillPresent = pres; flush = fl;
    @(posedge clk);
    modelEdge(fl, 1'b1, vpn, ppn, wr, pres);
    #1;
    fillEn = 1'b0; flush = 1'b0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    modelEdge(1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
    #1;
    flush = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: empty after reset
    look(32'h0000_0000, 1'b0, "R1");
    look(32'hFFFF_FFFF, 1'b1, "R1");
    look(32'h1234_5ABC, 1'b0, "R1");

    // R5: same-cycle lookup still sees old contents, new entry after the edge
    @(negedge clk);
    fillEn = 1'b1; fillVpn = 20'h12345; fillPpn = 18'h2ABCD;
    fillWrAllow = 1'b1; fillPresent = 1'b1;
    vAddr = 32'h1234_5678; isWrite = 1'b0;
    #1;
    checkNow("R5");
    @(posedge clk);
    modelEdge(1'b0, 1'b1, 20'h12345, 18'h2ABCD, 1'b1, 1'b1);
    #1;
    fillEn = 1'b0;
    look(32'h1234_5678, 1'b0, "R5");
    look(32'h1234_5FFF, 1'b1, "R2");
    look(32'h1234_6000, 1'b0, "R3");

    // R4: read-only page
    fill(20'h00010, 18'h00003, 1'b0, 1'b1, 1'b0);
    look(32'h0001_0ABC, 1'b1, "R4");
    look(32'h0001_0ABC, 1'b0, "R4");

    // R7: overwrite in place
    fill(20'h12345, 18'h11111, 1'b0, 1'b1, 1'b0);
    look(32'h1234_5010, 1'b0, "R7");
    look(32'h1234_5010, 1'b1, "R7");

    // R6: sixteen distinct pages from an empty table, then wrap
    doFlush();
    look(32'h1234_5010, 1'b0, "R8");
    for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 18'h00200 + 18'(i), 1'b1, 1'b1, 1'b0);
    look(32'h0010_0004, 1'b0, "R6");
    look(32'h0010_F004, 1'b0, "R6");
    fill(20'h00100, 18'h3FFFF, 1'b1, 1'b1, 1'b0);      // R7: pointer stays at 0
    look(32'h0010_0004, 1'b0, "R7");
    fill(20'h00200, 18'h00777, 1'b1, 1'b1, 1'b0);      // evicts slot 0
    look(32'h0010_0004, 1'b0, "R6");
    look(32'h0020_0004, 1'b0, "R6");
    fill(20'h00201, 18'h00778, 1'b1, 1'b1, 1'b0);      // evicts slot 1
    look(32'h0010_1004, 1'b0, "R6");
    look(32'h0010_2004, 1'b0, "R6");

    // R9: non-resident refills
    fill(20'h00300, 18'h00001, 1'b1, 1'b0, 1'b0);
    look(32'h0030_0000, 1'b0, "R9");
    fill(20'h00102, 18'h00001, 1'b1, 1'b0, 1'b0);
    look(32'h0010_2000, 1'b0, "R9");
    fill(20'h00202, 18'h00779, 1'b1, 1'b1, 1'b0);      // slot 2, pointer unmoved
    look(32'h0020_2000, 1'b0, "R9");
    look(32'h0010_3000, 1'b0, "R9");

    // R8: flush beats a simultaneous refill
    fill(20'h00400, 18'h00400, 1'b1, 1'b1, 1'b1);
    look(32'h0040_0000, 1'b0, "R8");
    look(32'h0010_3000, 1'b0, "R8");
    fill(20'h00500, 18'h00500, 1'b1, 1'b1, 1'b0);
    look(32'h0050_0123, 1'b0, "R8");

    // random mix over a 24-page pool
    for (int it = 0; it < 4000; it++) begin
      int op;
      logic [19:0] vpn;
      op  = $urandom % 100;
      vpn = (($urandom % 8) == 0) ? 20'($urandom) : 20'hA5000 + 20'($urandom % 24);
      if (op < 30) begin
        fill(vpn, 18'($urandom), 1'($urandom), ($urandom % 10) != 0, 1'b0);
      end else if (op < 31) begin
        doFlush();
      end else begin
        @(negedge clk);
        vAddr = {vpn, 12'($urandom)}; isWrite = 1'($urandom);
        #1;
        if (modelFind(vpn) < 0) checkNow("R3");
        else if (isWrite) checkNow("R4");
        else checkNow("R2");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule